// File: doc/BRIEF.md
# On-Demand DMA Request Port

This block is the controller-side front end through which an external device asks a DMA channel engine for transfers, with no request line per channel. The device first asks for the shared 32-bit data bus with a release-request input. The port grants it with a one-cycle bus-free pulse and stops driving the data bus two cycles later. In that same cycle the device raises a transfer strobe and presents a request word. The port decodes the word and hands the DMA engine a one-cycle request pulse, a channel number and a request-kind code.

Two shortcut requests need no request word. A transfer strobe on its own, while the port is idle, repeats the channel of the last captured request word. A release request and a strobe raised together in the same idle cycle ask for a direct transfer on channel 2. The port remembers the last captured channel for the repeat form and flags a repeat that has nothing to repeat.

The phase machine has four states. IDLE is the rest state and the only one that accepts requests. GRANT is the cycle in which bus-free is high. HOLD is the one cycle in which the controller still drives the bus. CAPTURE is the cycle in which the bus is released and the request word is sampled. The transitions are: IDLE to GRANT (release request without strobe), GRANT to HOLD (always), HOLD to CAPTURE (always), CAPTURE to IDLE (always). Every other IDLE case stays in IDLE (no request, a repeat, or a direct request).

Top module: `xfer_demand_port`

## Requirements
- R1: After reset, bus_free_o is 0, data_drive_o is 1, req_fire_o and repeat_err_o are 0, and no channel is remembered, so a repeat request is answered as in R8.
- R2: In IDLE, release_req_i high with xfer_strobe_i low gives bus_free_o high in the next cycle, and only for that one cycle.
- R3: data_drive_o is 0 in exactly one cycle, the second cycle after the cycle in which bus_free_o is high, and 1 in every other cycle.
- R4: In the data_drive_o = 0 cycle, xfer_strobe_i high with data_bus_i bit 31 set gives, in the next cycle, req_fire_o = 1, req_kind_o = 2'b01 (normal) and req_chan_o = data_bus_i[1:0]. Bits 30 to 2 have no effect, and that channel becomes the remembered one.
- R5: In the capture cycle, a word with bit 31 clear, or a low xfer_strobe_i, gives no pulse and leaves the remembered channel unchanged.
- R6: In IDLE, xfer_strobe_i high with release_req_i low, once a channel is remembered, gives in the next cycle req_fire_o = 1, req_kind_o = 2'b10 (repeat) and req_chan_o = the remembered channel.
- R7: In IDLE, release_req_i and xfer_strobe_i high together give in the next cycle req_fire_o = 1, req_kind_o = 2'b11 (direct) and req_chan_o = 2. They start no grant and leave the remembered channel unchanged.
- R8: A repeat request with no remembered channel gives no pulse and raises repeat_err_o for one cycle, the next one.
- R9: Both inputs are ignored in GRANT and HOLD, so with release_req_i held high successive bus_free_o pulses are four cycles apart.
- R10: When req_fire_o is 0, req_kind_o and req_chan_o read 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| release_req_i | input | 1 | Data-bus release request from the device |
| xfer_strobe_i | input | 1 | Transfer-request strobe from the device |
| data_bus_i | input | 32 | Sampled value of the shared data bus |
| bus_free_o | output | 1 | One-cycle bus-available pulse |
| data_drive_o | output | 1 | High while the controller drives the data bus |
| req_fire_o | output | 1 | One-cycle request pulse to the DMA engine |
| req_kind_o | output | 2 | 01 normal, 10 repeat, 11 direct, 00 none |
| req_chan_o | output | 2 | Requested channel |
| repeat_err_o | output | 1 | Repeat request with no remembered channel |

## Verification
The assertions take for granted that the device answers the release handshake only in the expected cycle. Any strobe raised during GRANT or HOLD is simply dropped, and the spacing properties depend on the reset phase having driven the grant history low. The stimulus moves the inputs only on falling clock edges, one cycle at a time. It includes deliberately misplaced strobes and release requests inside the window, to show that they are dropped and not treated as new requests. It also asserts reset in the middle of a grant, which clears the remembered channel.

// File: rtl/xdp_pkg.sv
package xdp_pkg;

    localparam int DATA_W    = 32;
    localparam int CHAN_W    = 2;
    localparam int VALID_BIT = DATA_W - 1;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_GRANT   = 2'd1,
        PH_HOLD    = 2'd2,
        PH_CAPTURE = 2'd3
    } phase_t;

    typedef enum logic [1:0] {
        KIND_NONE   = 2'b00,
        KIND_NORMAL = 2'b01,
        KIND_REPEAT = 2'b10,
        KIND_DIRECT = 2'b11
    } kind_t;

    typedef struct packed {
        logic              fire;
        kind_t             kind;
        logic [CHAN_W-1:0] chan;
        logic              err;
    } req_t;

endpackage

// File: rtl/xdp_phase_fsm.sv
module xdp_phase_fsm
    import xdp_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   release_req_i,
    input  logic   xfer_strobe_i,
    output phase_t phase_o,
    output logic   bus_free_o,
    output logic   data_drive_o
);

    phase_t phase_q;
    phase_t phase_d;

    // next-state selection
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (release_req_i && !xfer_strobe_i) begin
                    phase_d = PH_GRANT;
                end
            end
            PH_GRANT:   phase_d = PH_HOLD;
            PH_HOLD:    phase_d = PH_CAPTURE;
            PH_CAPTURE: phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
        end else begin
            phase_q <= phase_d;
        end
    end

    // outputs
    always_comb begin
        bus_free_o   = 1'b0;
        data_drive_o = 1'b1;
        unique case (phase_q)
            PH_IDLE:    ;
            PH_GRANT:   bus_free_o = 1'b1;
            PH_HOLD:    ;
            PH_CAPTURE: data_drive_o = 1'b0;
            default:    ;
        endcase
    end

    assign phase_o = phase_q;

    AST_GRANT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_o |=> !bus_free_o); // R2
    AST_RELEASE_LAG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_free_o, 2) |-> !data_drive_o); // R3
    AST_DRIVE_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        !data_drive_o |=> data_drive_o); // R3
    AST_NO_EARLY_REGRANT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_free_o, 2) || $past(bus_free_o, 3)) |-> !bus_free_o); // R9

endmodule

// File: rtl/xdp_req_decode.sv
module xdp_req_decode
    import xdp_pkg::*;
#(
    parameter int DIRECT_CHAN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_t            phase_i,
    input  logic              release_req_i,
    input  logic              xfer_strobe_i,
    input  logic [DATA_W-1:0] data_bus_i,
    output req_t              req_o
);

    localparam logic [CHAN_W-1:0] DIRECT_ID = CHAN_W'(DIRECT_CHAN);

    logic              mem_valid_q;
    logic [CHAN_W-1:0] mem_chan_q;
    req_t              req_d;

    always_comb begin
        req_d = '0;
        if (phase_i == PH_CAPTURE) begin
            if (xfer_strobe_i && data_bus_i[VALID_BIT]) begin
                req_d.fire = 1'b1;
                req_d.kind = KIND_NORMAL;
                req_d.chan = data_bus_i[CHAN_W-1:0];
            end
        end else if (phase_i == PH_IDLE && xfer_strobe_i) begin
            if (release_req_i) begin
                req_d.fire = 1'b1;
                req_d.kind = KIND_DIRECT;
                req_d.chan = DIRECT_ID;
            end else if (mem_valid_q) begin
                req_d.fire = 1'b1;
                req_d.kind = KIND_REPEAT;
                req_d.chan = mem_chan_q;
            end else begin
                req_d.err = 1'b1;
            end
        end
    end

    // remembered channel: only captured request words update it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_valid_q <= 1'b0;
            mem_chan_q  <= '0;
        end else if (req_d.fire && req_d.kind == KIND_NORMAL) begin
            mem_valid_q <= 1'b1;
            mem_chan_q  <= req_d.chan;
        end
    end

    assign req_o = req_d;

    AST_MEM_ONLY_ON_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_d.fire && req_d.kind == KIND_NORMAL) |=> $stable(mem_chan_q)); // R5
    AST_NO_FIRE_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i == PH_GRANT || phase_i == PH_HOLD) |-> !req_d.fire && !req_d.err); // R9

endmodule

// File: rtl/xdp_req_out.sv
module xdp_req_out
    import xdp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  req_t              req_i,
    output logic              req_fire_o,
    output logic [1:0]        req_kind_o,
    output logic [CHAN_W-1:0] req_chan_o,
    output logic              repeat_err_o
);

    req_t out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q.fire <= req_i.fire;
            out_q.err  <= req_i.err;
            out_q.kind <= req_i.fire ? req_i.kind : KIND_NONE;
            out_q.chan <= req_i.fire ? req_i.chan : '0;
        end
    end

    assign req_fire_o   = out_q.fire;
    assign req_kind_o   = out_q.kind;
    assign req_chan_o   = out_q.chan;
    assign repeat_err_o = out_q.err;

    AST_QUIET_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        !req_fire_o |-> (req_kind_o == 2'b00 && req_chan_o == '0)); // R10
    AST_ERR_NOT_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        !(repeat_err_o && req_fire_o)); // R8
    AST_FIRE_HAS_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_fire_o |-> req_kind_o != 2'b00); // R4

endmodule

// File: rtl/xfer_demand_port.sv
module xfer_demand_port
    import xdp_pkg::*;
#(
    parameter int DIRECT_CHAN = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              release_req_i,
    input  logic              xfer_strobe_i,
    input  logic [DATA_W-1:0] data_bus_i,
    output logic              bus_free_o,
    output logic              data_drive_o,
    output logic              req_fire_o,
    output logic [1:0]        req_kind_o,
    output logic [CHAN_W-1:0] req_chan_o,
    output logic              repeat_err_o
);

    phase_t phase;
    req_t   req_next;

    xdp_phase_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .release_req_i (release_req_i),
        .xfer_strobe_i (xfer_strobe_i),
        .phase_o       (phase),
        .bus_free_o    (bus_free_o),
        .data_drive_o  (data_drive_o)
    );

    xdp_req_decode #(
        .DIRECT_CHAN (DIRECT_CHAN)
    ) u_dec (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase_i       (phase),
        .release_req_i (release_req_i),
        .xfer_strobe_i (xfer_strobe_i),
        .data_bus_i    (data_bus_i),
        .req_o         (req_next)
    );

    xdp_req_out u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req_next),
        .req_fire_o   (req_fire_o),
        .req_kind_o   (req_kind_o),
        .req_chan_o   (req_chan_o),
        .repeat_err_o (repeat_err_o)
    );

    AST_DIRECT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire_o && req_kind_o == 2'b11) |-> (!bus_free_o && req_chan_o == CHAN_W'(DIRECT_CHAN))); // R7
    AST_FIRE_NOT_IN_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_free_o |-> !req_fire_o); // R9

endmodule

// File: tb/xfer_demand_port_test.sv
module xfer_demand_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rel = 1'b0;
    logic        trq = 1'b0;
    logic [31:0] data = 32'h0;
    logic        bus_free, drive, fire, err;
    logic [1:0]  kind, chan;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    xfer_demand_port uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .release_req_i (rel),
        .xfer_strobe_i (trq),
        .data_bus_i    (data),
        .bus_free_o    (bus_free),
        .data_drive_o  (drive),
        .req_fire_o    (fire),
        .req_kind_o    (kind),
        .req_chan_o    (chan),
        .repeat_err_o  (err)
    );

    // {req#, rel, trq, data, exp: free, drive, fire, kind, chan, err}
    localparam int NV = 24;
    localparam logic [45:0] VEC [NV] = '{
        {4'd8,  1'b0, 1'b1, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b1}, // R8 repeat w/o memory
        {4'd10, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R10 quiet
        {4'd2,  1'b1, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R2 grant
        {4'd9,  1'b1, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R9 rel in GRANT ignored
        {4'd3,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'b00, 2'd0, 1'b0}, // R3 released
        {4'd4,  1'b0, 1'b1, 32'h8000_0001, 1'b0, 1'b1, 1'b1, 2'b01, 2'd1, 1'b0}, // R4 normal ch1
        {4'd10, 1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R10
        {4'd6,  1'b0, 1'b1, 32'h0,         1'b0, 1'b1, 1'b1, 2'b10, 2'd1, 1'b0}, // R6 repeat ch1
        {4'd7,  1'b1, 1'b1, 32'h0,         1'b0, 1'b1, 1'b1, 2'b11, 2'd2, 1'b0}, // R7 direct
        {4'd7,  1'b0, 1'b1, 32'h0,         1'b0, 1'b1, 1'b1, 2'b10, 2'd1, 1'b0}, // R7 memory kept
        {4'd2,  1'b1, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R2
        {4'd3,  1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R3 still driving
        {4'd3,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'b00, 2'd0, 1'b0}, // R3
        {4'd5,  1'b0, 1'b1, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R5 invalid word
        {4'd5,  1'b0, 1'b1, 32'h0,         1'b0, 1'b1, 1'b1, 2'b10, 2'd1, 1'b0}, // R5 memory kept
        {4'd2,  1'b1, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R2
        {4'd9,  1'b0, 1'b1, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R9 strobe in GRANT ignored
        {4'd3,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'b00, 2'd0, 1'b0}, // R3
        {4'd5,  1'b0, 1'b0, 32'h8000_0002, 1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R5 no strobe
        {4'd2,  1'b1, 1'b0, 32'h0,         1'b1, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R2
        {4'd3,  1'b0, 1'b0, 32'h0,         1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}, // R3
        {4'd3,  1'b0, 1'b0, 32'h0,         1'b0, 1'b0, 1'b0, 2'b00, 2'd0, 1'b0}, // R3
        {4'd4,  1'b0, 1'b1, 32'hFFFF_FFFE, 1'b0, 1'b1, 1'b1, 2'b01, 2'd2, 1'b0}, // R4 upper bits ignored
        {4'd6,  1'b0, 1'b1, 32'h0,         1'b0, 1'b1, 1'b1, 2'b10, 2'd2, 1'b0}  // R6 repeat ch2
    };

    task automatic check(input string what, input int req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL R%0d %s got %h expected %h", req, what, got, exp);
        end
    endtask

    function automatic logic [7:0] outs();
        return {bus_free, drive, fire, kind, chan, err};
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        int grants;
        repeat (2) @(negedge clk);
        check("reset state", 1, outs(), {1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}); // R1
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            rel  = VEC[i][41];
            trq  = VEC[i][40];
            data = VEC[i][39:8];
            @(negedge clk);
            check($sformatf("vector %0d", i), int'(VEC[i][45:42]), outs(), {1'b0, VEC[i][7:0]});
        end
        rel = 1'b0; trq = 1'b0; data = '0;
        @(negedge clk);

        // R9: release held high, grants four cycles apart
        grants = 0;
        rel = 1'b1;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (bus_free) grants++;
        end
        rel = 1'b0;
        check("grants in 8 cycles", 9, 8'(grants), 8'd2); // R9
        repeat (4) @(negedge clk);

        // R1: reset in the middle of a grant
        rel = 1'b1;
        @(negedge clk);
        rel = 1'b0;
        check("grant before reset", 2, {7'd0, bus_free}, 8'd1); // R2
        rst_n = 1'b0;
        #1;
        check("reset mid grant", 1, outs(), {1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b0}); // R1
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        trq = 1'b1;
        @(negedge clk);
        trq = 1'b0;
        check("memory cleared by reset", 1, outs(), {1'b0, 1'b1, 1'b0, 2'b00, 2'd0, 1'b1}); // R1 R8
        @(negedge clk);
        check("error lasts one cycle", 8, {7'd0, err}, 8'd0); // R8

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule